// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

The block is a single event timer that counts down one step for every cycle in which its tick strobe is high. Two word registers on a simple write port control it. The trigger register carries an enable flag, a periodic flag and a reload count. The control/status register acknowledges the interrupt and shows the live count. When the count runs out, the block raises a level interrupt. In one-shot mode the timer then parks itself. In periodic mode it reloads and keeps firing at a fixed spacing.

The count uses an n+1 encoding: a reload value of N produces an event on the (N+1)-th tick after arming, so a value of 0 fires on the first tick. Reads are combinational from the address. A system instantiates one copy of the block per event source.

Top module: `evt_tmr`

## Requirements
- R1: After reset, both register offsets read 0 and irq_o is low.
- R2: The trigger register is at byte offset 0x0. Bit 31 is enable, bit 30 is periodic and bits 28:0 are the reload count. Reading offset 0x0 returns the last written enable, periodic and count fields, and bit 29 reads 0.
- R3: Once armed with count N and enable set, irq_o stays low through the first N tick cycles and is high after the (N+1)-th. Cycles with tick_i low do not advance the count.
- R4: In one-shot mode (bit 30 = 0), an expiry clears the enable bit seen at offset 0x0 and leaves the count at 0. Later ticks raise no new event.
- R5: In periodic mode (bit 30 = 1), an expiry reloads N into the count and keeps enable set. The next event follows after another N+1 ticks.
- R6: Any write to offset 0x0 copies bits 28:0 into the counter. With enable clear, ticks leave the count unchanged and raise no event.
- R7: The control register is at byte offset 0x4. Writing it with bit 30 = 1 clears the pending interrupt. Writing it with bit 30 = 0 leaves the interrupt pending. Writes to 0x4 never change the trigger register.
- R8: irq_o holds high until cleared. When an expiry and a clear fall in the same cycle, irq_o stays high.
- R9: A write to offset 0x0 with enable set reloads the count at once. A tick in the same cycle as that write is not counted.
- R10: Offset 0x4 reads the live count in bits 28:0 and the pending interrupt in bit 30.
- R11: The full count 0x1FFFFFFF loads, reads back, and decrements to 0x1FFFFFFE on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt, pending expiry |

## Verification
The assertions assume at most one register write per cycle. They also assume that tick_i is sampled per cycle, so a strobe held high counts once in every cycle it stays high. The stimulus drives all inputs at the falling edge and holds each for exactly one rising edge, so every tick and write is seen exactly once. It separates ticks with idle cycles so that no-tick cycles are checked for having no effect. Count sweeps stay small so that expiry is reached within the run. The full-width count is checked only for loading and the first decrement.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_TRIG = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h4;

  localparam int EN_BIT   = 31;
  localparam int PER_BIT  = 30;
  localparam int CLR_BIT  = 30;
  localparam int PEND_BIT = 30;

  typedef struct packed {
    logic en;
    logic per;
  } tmr_mode_t;
endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_we_i,
  input  logic             en_i,
  input  logic             per_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             expire_i,
  output tmr_mode_t        mode_o,
  output logic [CNT_W-1:0] reload_o
);
  tmr_mode_t        mode_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      reload_q <= '0;
    end else if (trig_we_i) begin
      mode_q.en  <= en_i;
      mode_q.per <= per_i;
      reload_q   <= reload_i;
    end else if (expire_i && !mode_q.per) begin
      mode_q.en <= 1'b0;  // one-shot parks itself
    end
  end

  assign mode_o   = mode_q;
  assign reload_o = reload_q;

  p_oneshot_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !mode_q.per && !trig_we_i |=> !mode_q.en);

  p_periodic_keeps_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && mode_q.per && !trig_we_i |=> mode_q.en && mode_q.per);

  p_reload_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_we_i |=> $stable(reload_q));
endmodule

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  input  logic             per_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = en_i && tick_i && !load_i;
  assign expire_o = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;  // write wins over a same-cycle tick
    end else if (expire_o) begin
      if (per_i) cnt_q <= reload_i;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && !load_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && per_i |=> cnt_q == $past(reload_i));

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !(en_i && tick_i) |=> $stable(cnt_q));

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/evt_tmr_irq.sv
module evt_tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;  // new expiry beats clear
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);

  p_level_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !pend_q);

  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !set_i |=> !pend_q);
endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  tmr_mode_t        mode;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             pend;
  logic             trig_we;
  logic             ctrl_we;
  logic             clr;
  logic             unused_wdata;

  assign trig_we      = wr_en_i && (addr_i == OFS_TRIG);
  assign ctrl_we      = wr_en_i && (addr_i == OFS_CTRL);
  assign clr          = ctrl_we && wdata_i[CLR_BIT];
  assign unused_wdata = ^wdata_i;

  evt_tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_we_i (trig_we),
    .en_i      (wdata_i[EN_BIT]),
    .per_i     (wdata_i[PER_BIT]),
    .reload_i  (wdata_i[CNT_W-1:0]),
    .expire_i  (expire),
    .mode_o    (mode),
    .reload_o  (reload)
  );

  evt_tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (trig_we),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .en_i       (mode.en),
    .per_i      (mode.per),
    .tick_i     (tick_i),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  evt_tmr_irq irq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (clr),
    .pend_o (pend)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_TRIG: begin
        rdata_o[EN_BIT]    = mode.en;
        rdata_o[PER_BIT]   = mode.per;
        rdata_o[CNT_W-1:0] = reload;
      end
      OFS_CTRL: begin
        rdata_o[PEND_BIT]  = pend;
        rdata_o[CNT_W-1:0] = cnt;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = pend;

  p_ctrl_write_keeps_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> $stable(reload));

  p_idle_no_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode.en && !irq_o |=> !irq_o);
endmodule

// File: tb/evt_tmr_tb_top.sv
module evt_tmr_tb_top;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] PER = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick_i;
  logic        wr_en_i;
  logic [2:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_tmr dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t);
    tick_i = t;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic t);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    tick_i  = t;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
    tick_i  = 1'b0;
    wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] trig;
    rst_ni = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'h0, d); chk("R1 trigger after reset", d, 32'h0);
    rd(3'h4, d); chk("R1 control after reset", d, 32'h0);
    chk("R1 irq after reset", 32'(irq_o), 32'h0);

    // sweep both modes over small counts
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 7; n++) begin
        wr(3'h4, CLR, 1'b0);
        trig = EN | (m != 0 ? PER : 32'h0) | 32'(n);
        wr(3'h0, trig, 1'b0);
        rd(3'h0, d); chk("R2 trigger readback", d, trig);
        for (int k = 1; k <= n + 1; k++) begin
          step(1'b0);
          chk("R3 idle cycle raises nothing", 32'(irq_o), 32'h0);
          step(1'b1);
          rd(3'h4, d);
          if (k <= n) begin
            chk("R3 no early irq", 32'(irq_o), 32'h0);
            chk("R10 live count", 32'(d[28:0]), 32'(n - k));
          end else begin
            chk("R3 fires after N+1 ticks", 32'(irq_o), 32'h1);
          end
        end
        rd(3'h4, d); chk("R10 pending bit", 32'(d[30]), 32'h1);
        if (m != 0) begin
          chk("R5 count reloaded", 32'(d[28:0]), 32'(n));
          rd(3'h0, d); chk("R5 enable kept", d, trig);
          wr(3'h4, CLR, 1'b0);
          chk("R7 clear drops irq", 32'(irq_o), 32'h0);
          for (int k = 1; k <= n + 1; k++) begin
            step(1'b1);
            chk("R5 periodic spacing", 32'(irq_o), (k == n + 1) ? 32'h1 : 32'h0);
          end
        end else begin
          rd(3'h0, d); chk("R4 enable cleared", d, trig & ~EN);
          wr(3'h4, CLR, 1'b0);
          chk("R7 clear drops irq", 32'(irq_o), 32'h0);
          repeat (3) step(1'b1);
          chk("R4 no restart", 32'(irq_o), 32'h0);
          rd(3'h4, d); chk("R4 count parked", 32'(d[28:0]), 32'h0);
        end
      end
    end
    wr(3'h4, CLR, 1'b0);

    // R6 disabled write freezes count
    wr(3'h0, EN | 32'd9, 1'b0);
    step(1'b1); step(1'b1);
    rd(3'h4, d); chk("R6 running count", 32'(d[28:0]), 32'd7);
    wr(3'h0, 32'd5, 1'b0);
    rd(3'h0, d); chk("R6 trigger disabled", d, 32'd5);
    repeat (8) step(1'b1);
    rd(3'h4, d); chk("R6 count frozen", d, 32'd5);
    chk("R6 no irq when disabled", 32'(irq_o), 32'h0);

    // R9 restart with tick in same cycle
    wr(3'h0, EN | 32'd5, 1'b0);
    step(1'b1); step(1'b1);
    rd(3'h4, d); chk("R9 before restart", 32'(d[28:0]), 32'd3);
    wr(3'h0, EN | 32'd4, 1'b1);
    rd(3'h4, d); chk("R9 reload ignores same tick", 32'(d[28:0]), 32'd4);
    step(1'b1);
    rd(3'h4, d); chk("R9 counts after restart", 32'(d[28:0]), 32'd3);

    // R7 clear bit low has no effect, R8 level hold
    wr(3'h0, EN, 1'b0);
    step(1'b1);
    chk("R3 zero fires on first tick", 32'(irq_o), 32'h1);
    wr(3'h4, 32'hBFFF_FFFF, 1'b0);
    chk("R7 write without clear bit", 32'(irq_o), 32'h1);
    rd(3'h0, d); chk("R7 trigger untouched", d, 32'h0);
    repeat (3) step(1'b0);
    chk("R8 level held", 32'(irq_o), 32'h1);
    wr(3'h0, EN | PER, 1'b0);
    wr(3'h4, CLR, 1'b1);
    chk("R8 expiry beats clear", 32'(irq_o), 32'h1);
    wr(3'h4, CLR, 1'b0);
    chk("R7 clear after collision", 32'(irq_o), 32'h0);
    repeat (3) step(1'b0);
    chk("R8 stays low without ticks", 32'(irq_o), 32'h0);

    // R11 full-width count
    wr(3'h0, EN | 32'h1FFF_FFFF, 1'b0);
    rd(3'h0, d); chk("R11 max readback", d, EN | 32'h1FFF_FFFF);
    rd(3'h4, d); chk("R11 max count", 32'(d[28:0]), 32'h1FFF_FFFF);
    step(1'b1);
    rd(3'h4, d); chk("R11 first decrement", 32'(d[28:0]), 32'h1FFF_FFFE);
    chk("R11 no irq", 32'(irq_o), 32'h0);
    wr(3'h0, 32'h0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule